// File: doc/BRIEF.md
# Flash Program/Erase Control and Status Register

This block is a single byte-wide register placed between a CPU register bus and the embedded program/erase algorithm engine of a flash memory. It holds two live bits: an interrupt enable and a ready flag. When the algorithm engine pulses its completion line, the ready flag is set. Software clears the flag by writing a zero to it. Writing a one to the flag does nothing.

The block drives a level interrupt request while both bits are set. It also drives a permit output that follows the ready flag. A start request from the bus reaches the engine only while the permit is high. An accepted start clears the flag, which marks the operation as in progress until the next completion pulse.

Reads are registered. The flag bit reads as one during the read phase of a read-modify-write access. This keeps a read-modify-write of the enable bit from clearing the flag by accident. The register answers only at its own byte address, which is a parameter (default 0x0000AE). The control pins are plain level or pulse signals, with no handshake.

Top module: `flash_ctl_status_reg`

## Requirements
- R1: After reset the enable bit and the ready flag are 0, `irq` and `op_permit` are low, and `bus_rdata` is 0x00.
- R2: `irq` is high exactly when the enable bit and the ready flag are both 1. It falls in the cycle after a write that clears either bit.
- R3: A one-cycle `algo_done` pulse sets the ready flag from the next clock edge onward.
- R4: A write to the register with data bit 6 = 0 clears the ready flag. A write with bit 6 = 1 leaves the flag unchanged.
- R5: If `algo_done` arrives in the same cycle as a clearing write or an accepted start, the flag ends up set.
- R6: A read with `bus_rmw` high returns bit 6 = 1 whatever the flag holds. A read with `bus_rmw` low returns the real flag. Neither kind of read changes the flag.
- R7: `op_permit` equals the ready flag. While it is low, `start_req` produces no `algo_start` and changes no state.
- R8: While `op_permit` is high, `start_req` drives `algo_start` high in the same cycle, and the flag is 0 after that clock edge.
- R9: Bits 5..0 read as 0 and ignore writes. Writes and reads at any other address change nothing, and such reads return 0x00.
- R10: `bus_rdata` shows the register one cycle after a read strobe that hits the address, and is 0x00 in every other cycle.
- R11: A write to the register loads the enable bit (bit 7) from data bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rmw | input | 1 | Marks the read as the read phase of a read-modify-write |
| bus_rdata | output | 8 | Registered read data |
| algo_done | input | 1 | Completion pulse from the program/erase algorithm engine |
| start_req | input | 1 | Request to start a program/erase operation |
| algo_start | output | 1 | Start pulse to the algorithm engine, gated by the permit |
| irq | output | 1 | Level interrupt request |
| op_permit | output | 1 | High when a new program/erase operation may start |

## Verification
The hardest case to reach from the ports is a same-cycle collision between a completion pulse and something that clears the flag, either a zero-write or an accepted start. The bench raises `algo_done` in the same cycle as the other stimulus and then checks that the flag ends up set. The read-modify-write view is checked by reading the cleared flag twice, once with the qualifier and once without. A final normal read shows that the qualified read left the flag unchanged.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int DATA_W  = 8;
  localparam int IEN_BIT = 7;
  localparam int RDY_BIT = 6;
endpackage

// File: rtl/fcsr_decode.sv
module fcsr_decode #(
  parameter int              ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hAE
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic sel;
  assign sel    = (addr == REG_ADDR);
  assign wr_hit = wr & sel;
  assign rd_hit = rd & sel;
endmodule

// File: rtl/fcsr_state.sv
module fcsr_state (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wdata_en,
  input  logic wdata_rdy,
  input  logic done,
  input  logic start_req,
  output logic en_q,
  output logic flag_q,
  output logic start_acc
);
  logic flag_d;

  assign start_acc = start_req & flag_q;

  always_comb begin
    flag_d = flag_q;
    if (done)                      flag_d = 1'b1;
    else if (wr_hit && !wdata_rdy) flag_d = 1'b0;
    else if (start_acc)            flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_hit) en_q <= wdata_en;
      flag_q <= flag_d;
    end
  end

  assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);
  assert_zero_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wdata_rdy && !done) |=> !flag_q);
  assert_one_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata_rdy && !done && !start_acc) |=> flag_q == $past(flag_q));
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && !done) |=> !flag_q);
  assert_enable_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> en_q == $past(wdata_en));
endmodule

// File: rtl/fcsr_readback.sv
module fcsr_readback
  import fcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  logic              rmw,
  input  logic              en_q,
  input  logic              flag_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] view;

  always_comb begin
    view          = '0;
    view[IEN_BIT] = en_q;
    view[RDY_BIT] = flag_q | rmw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_hit) rdata <= view;
    else             rdata <= '0;
  end

  assert_rmw_reads_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rmw) |=> rdata[RDY_BIT]);
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> rdata == '0);
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[RDY_BIT-1:0] == '0);
endmodule

// File: rtl/flash_ctl_status_reg.sv
module flash_ctl_status_reg
  import fcsr_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hAE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_rmw,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              algo_done,
  input  logic              start_req,
  output logic              algo_start,
  output logic              irq,
  output logic              op_permit
);
  logic wr_hit, rd_hit, en_q, flag_q;
  logic wdata_unused;

  assign wdata_unused = ^bus_wdata[RDY_BIT-1:0];

  fcsr_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_decode (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  fcsr_state u_state (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
    .wdata_en(bus_wdata[IEN_BIT]), .wdata_rdy(bus_wdata[RDY_BIT]),
    .done(algo_done), .start_req(start_req),
    .en_q(en_q), .flag_q(flag_q), .start_acc(algo_start)
  );

  fcsr_readback u_readback (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .rmw(bus_rmw),
    .en_q(en_q), .flag_q(flag_q), .rdata(bus_rdata)
  );

  assign irq       = en_q & flag_q;
  assign op_permit = flag_q;

  assert_done_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    algo_done |=> op_permit);
  assert_blocked_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_permit && !algo_done) |=> !op_permit);
  assert_irq_en_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !bus_wdata[IEN_BIT]) |=> !irq);
endmodule

// File: tb/flash_ctl_status_reg_bench.sv
module flash_ctl_status_reg_bench;
  localparam int AW = 24;
  localparam logic [AW-1:0] RA = 24'h0000AE;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0, bus_rmw = 0, algo_done = 0, start_req = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic algo_start, irq, op_permit;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_ctl_status_reg #(.ADDR_W(AW), .REG_ADDR(RA)) u_flash_ctl_status_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
    .bus_rdata(bus_rdata), .algo_done(algo_done), .start_req(start_req),
    .algo_start(algo_start), .irq(irq), .op_permit(op_permit)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic rmw, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rmw = rmw; bus_rd = 1;
    @(negedge clk); d = bus_rdata; bus_rd = 0; bus_rmw = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); algo_done = 1;
    @(negedge clk); algo_done = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 permit", {7'd0, op_permit}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rd(RA, 0, d);
    check("R1 read", d, 8'h00);
  endtask

  task automatic t_blocked_start();
    logic [7:0] d;
    @(negedge clk); start_req = 1;
    #5 check("R7 no start", {7'd0, algo_start}, 8'h00);
    @(negedge clk); start_req = 0;
    check("R7 permit low", {7'd0, op_permit}, 8'h00);
    rd(RA, 0, d);
    check("R7 state kept", d, 8'h00);
  endtask

  task automatic t_done_and_clear();
    logic [7:0] d;
    done_pulse();
    check("R3 permit set", {7'd0, op_permit}, 8'h01);
    rd(RA, 0, d);
    check("R3 read", d, 8'h40);
    wr(RA, 8'h40);
    rd(RA, 0, d);
    check("R4 write one no effect", d, 8'h40);
    wr(RA, 8'h00);
    rd(RA, 0, d);
    check("R4 write zero clears", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    done_pulse();
    wr(RA, 8'hC0);
    check("R2 irq on", {7'd0, irq}, 8'h01);
    rd(RA, 0, d);
    check("R11 enable set", d, 8'hC0);
    wr(RA, 8'h80);
    check("R2 irq off by flag clear", {7'd0, irq}, 8'h00);
    done_pulse();
    check("R2 irq back", {7'd0, irq}, 8'h01);
    wr(RA, 8'h40);
    check("R2 irq off by enable", {7'd0, irq}, 8'h00);
    rd(RA, 0, d);
    check("R11 enable cleared", d, 8'h40);
  endtask

  task automatic t_rmw();
    logic [7:0] d;
    wr(RA, 8'h00);
    rd(RA, 0, d);
    check("R6 normal read", d, 8'h00);
    rd(RA, 1, d);
    check("R6 rmw read", d, 8'h40);
    rd(RA, 0, d);
    check("R6 flag untouched", d, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk); bus_addr = RA; bus_wdata = 8'h00; bus_wr = 1; algo_done = 1;
    @(negedge clk); bus_wr = 0; algo_done = 0;
    rd(RA, 0, d);
    check("R5 done beats clear", d, 8'h40);
    @(negedge clk); start_req = 1; algo_done = 1;
    @(negedge clk); start_req = 0; algo_done = 0;
    check("R5 done beats start", {7'd0, op_permit}, 8'h01);
  endtask

  task automatic t_start();
    @(negedge clk); start_req = 1;
    #5 check("R8 start pulse", {7'd0, algo_start}, 8'h01);
    @(negedge clk); start_req = 0;
    check("R8 flag cleared", {7'd0, op_permit}, 8'h00);
    check("R8 start gone", {7'd0, algo_start}, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    done_pulse();
    wr(RA, 8'hFF);
    rd(RA, 0, d);
    check("R9 reserved zero", d, 8'hC0);
    wr(RA + 1, 8'h00);
    rd(RA, 0, d);
    check("R9 other address write ignored", d, 8'hC0);
    rd(RA - 1, 0, d);
    check("R9 other address read", d, 8'h00);
    @(negedge clk);
    check("R10 idle rdata", bus_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_blocked_start();
    t_done_and_clear();
    t_irq();
    t_rmw();
    t_collision();
    t_start();
    t_reserved();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule